// File: doc/BRIEF.md
# Posted-Write Register Clock-Domain Bridge

This block connects a fast host register bus to a bank of ten registers that are used in a slow functional clock domain. A host write to one of these registers is captured in the bus clock and carried across with a toggle handshake. The target register is updated in the slow domain, and the acknowledge is returned through a two-flop synchroniser. Each register has its own write-in-flight flag. Software can poll all ten flags at once through a status word.

A mode bit selects how writes complete. In posted mode, which is the default, the bus write completes at once. A second write to a register that is still in flight is discarded. In non-posted mode the bus ready signal is held low until the slow-domain update has been acknowledged. Host reads of a tracked register return the last value the slow domain has acknowledged. The mode bit itself is a host-domain register and is written directly, without any handshake.

Top module: `pwb_bridge`

## Requirements
- R1: After reset, the status word at offset 0x34 reads 0. The mode word at offset 0x40 reads 4, because its bit 2 (posted) resets to 1. Every tracked register reads 0, and `s_regs` and `s_upd` are 0.
- R2: Each accepted write updates the slow-domain copy of its register exactly once. The update carries the written data and is marked by a single-slow-cycle pulse on that register's `s_upd` bit.
- R3: The tracked registers are at offsets 0x24, 0x28, 0x2C and 0x30 (status bits 0 to 3), 0x38 (bit 4) and 0x48, 0x4C, 0x50, 0x54 and 0x58 (bits 5 to 9). A register's status bit reads 1 from the bus cycle that follows acceptance of its write.
- R4: A status bit returns to 0 once the slow-domain acknowledge has passed the two-flop synchroniser. This takes no more than about three slow cycles plus three bus cycles. From then on, a read of that register returns the new data.
- R5: In posted mode, a write to a register whose status bit is 1 is discarded. The register keeps the in-flight value, and no extra slow-domain update takes place.
- R6: A read of a register whose status bit is 1 returns the value acknowledged before, not the in-flight data.
- R7: In non-posted mode (mode bit 2 = 0), `bus_ready` stays low during a tracked write until that register's status bit has cleared. After the write completes, the status bit already reads 0.
- R8: The mode word is written directly. It completes with `bus_ready` high, has no status bit and reads back the written bit 2 on the next cycle.
- R9: Writes to different registers may be in flight together, and each sets its own status bit. A register written later is never updated in the slow domain before one written earlier.
- R10: In posted mode, a tracked write completes in its first cycle, with `bus_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| sclk | input | 1 | Slow functional clock |
| srst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write request, held until `bus_ready` |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed word |
| bus_ready | output | 1 | Access completes on a clock edge with this high |
| s_regs | output | 10*DW | Slow-domain register copies, register i at bits i*DW upward |
| s_upd | output | 10 | One-slow-cycle pulse when a register is updated |

## Verification
The bench builds the bridge with DW = 32. It runs the slow clock at one sixth of the bus clock, so every handshake spans many bus cycles. This leaves enough time to stack a second write on a pending register and to read a register while its write is still in flight. Two registers can also be put in flight together and the order of their slow-domain pulses compared. Running in non-posted mode makes the bus stall several bus cycles long, so the bench can measure it.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    // Number of handshake-tracked registers and the fixed host-domain offsets
    localparam int NREG = 10;
    localparam logic [7:0] PEND_OFS = 8'h34;
    localparam logic [7:0] MODE_OFS = 8'h40;
    localparam int POSTED_BIT = 2;

    typedef enum logic {ST_IDLE, ST_WAIT} bus_st_t;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } slot_t;

    // Maps a byte offset onto a tracked register slot (status bit index)
    function automatic slot_t map_addr(input logic [7:0] a);
        slot_t s;
        s.hit = 1'b0;
        s.idx = 4'd0;
        if (a[1:0] == 2'b00) begin
            if (a >= 8'h24 && a <= 8'h30) begin
                s.hit = 1'b1;
                s.idx = 4'(a[5:2] - 4'd9);
            end else if (a == 8'h38) begin
                s.hit = 1'b1;
                s.idx = 4'd4;
            end else if (a >= 8'h48 && a <= 8'h58) begin
                s.hit = 1'b1;
                s.idx = 4'(a[7:2] - 6'd13);
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/pwb_sync2.sv
// Two-flop synchroniser for one level signal.
// Assumes d changes at most once per several destination cycles (toggle handshake).
module pwb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Two-stage resampling into the destination clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pwb_chan.sv
// One tracked register: capture in the bus clock, toggle request into the slow
// clock, toggle acknowledge back. Assumes cap_q is held stable while pending,
// which the drop-on-pending rule guarantees.
module pwb_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          srst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    output logic [DW-1:0] done_val,
    output logic [DW-1:0] s_val,
    output logic          s_upd
);
    logic          req_t, ack_t, req_s, ack_h, pend_q;
    logic [DW-1:0] cap_q, done_q, s_q;
    logic          upd_q;

    pwb_sync2 u_ack_sync (.clk(clk),  .rst_n(rst_n),  .d(ack_t), .q(ack_h));
    pwb_sync2 u_req_sync (.clk(sclk), .rst_n(srst_n), .d(req_t), .q(req_s));

    // Bus side: accept when idle, drop when pending, commit on returned ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_t  <= 1'b0;
            pend_q <= 1'b0;
            cap_q  <= '0;
            done_q <= '0;
        end else if (load && !pend_q) begin
            cap_q  <= wdata;
            req_t  <= ~req_t;
            pend_q <= 1'b1;
        end else if (pend_q && (ack_h == req_t)) begin
            pend_q <= 1'b0;
            done_q <= cap_q;
        end
    end

    // Slow side: apply captured data once per request toggle
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            ack_t <= 1'b0;
            s_q   <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (req_s != ack_t) begin
                s_q   <= cap_q;
                ack_t <= req_s;
                upd_q <= 1'b1;
            end
        end
    end

    assign pend     = pend_q;
    assign done_val = done_q;
    assign s_val    = s_q;
    assign s_upd    = upd_q;

    // R3: an accepted write raises the pending flag on the next cycle
    a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !pend_q) |=> pend_q);
    // R5: a write arriving while pending leaves the in-flight data alone
    a_r5_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (load && pend_q) |=> ($stable(cap_q) && $stable(req_t)));
    // R2: each slow-domain update is a single-cycle pulse
    a_r2_one_pulse: assert property (@(posedge sclk) disable iff (!srst_n)
        upd_q |=> !upd_q);
endmodule

// File: rtl/pwb_bridge.sv
// Posted-write bridge top: address decode, mode bit, stall state machine and
// read mux over ten handshake-tracked registers. Assumes the host holds
// bus_wr, bus_addr and bus_wdata until it sees bus_ready high at a clock edge.
module pwb_bridge
    import pwb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               srst_n,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_ready,
    output logic [NREG*DW-1:0] s_regs,
    output logic [NREG-1:0]    s_upd
);
    slot_t           slot;
    bus_st_t         st_q, st_n;
    logic [3:0]      widx_q;
    logic            posted_q;
    logic [NREG-1:0] load_v, pend;
    logic [DW-1:0]   done_a [NREG];

    assign slot = map_addr(bus_addr);

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_chan
            pwb_chan #(.DW(DW)) u_chan (
                .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
                .load(load_v[gi]), .wdata(bus_wdata), .pend(pend[gi]),
                .done_val(done_a[gi]), .s_val(s_regs[gi*DW +: DW]),
                .s_upd(s_upd[gi]));
        end
    endgenerate

    // Decide load strobes, bus ready and next stall state
    always_comb begin
        load_v    = '0;
        bus_ready = 1'b1;
        st_n      = st_q;
        case (st_q)
            ST_IDLE: begin
                if (bus_wr && slot.hit) begin
                    if (posted_q) begin
                        load_v = NREG'(1) << slot.idx;
                    end else begin
                        bus_ready = 1'b0;
                        if (!pend[slot.idx]) begin
                            load_v = NREG'(1) << slot.idx;
                            st_n   = ST_WAIT;
                        end
                    end
                end
            end
            default: begin
                bus_ready = !pend[widx_q];
                if (!pend[widx_q]) st_n = ST_IDLE;
            end
        endcase
    end

    // Stall state and the register index being waited on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            widx_q <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_IDLE && st_n == ST_WAIT) widx_q <= slot.idx;
        end
    end

    // Directly written mode register, posted by default
    always_ff @(posedge clk) begin
        if (!rst_n)
            posted_q <= 1'b1;
        else if (bus_wr && st_q == ST_IDLE && bus_addr == MODE_OFS)
            posted_q <= bus_wdata[POSTED_BIT];
    end

    // Read mux: status word, mode word, or last acknowledged register value
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == PEND_OFS)
            bus_rdata = DW'(pend);
        else if (bus_addr == MODE_OFS)
            bus_rdata[POSTED_BIT] = posted_q;
        else if (slot.hit)
            bus_rdata = done_a[slot.idx];
    end

    // R7: while waiting on a pending register the bus stays stalled
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && pend[widx_q]) |-> !bus_ready);
    // R10: posted tracked writes never stall
    a_r10_posted_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && posted_q && bus_wr) |-> bus_ready);
endmodule

// File: tb/pwb_bridge_test.sv
module pwb_bridge_test;
    localparam int DW = 32;
    localparam int NR = 10;

    logic clk = 0, sclk = 0, rst_n = 0, srst_n = 0;
    logic [7:0]     bus_addr = 0;
    logic           bus_wr = 0, bus_rd = 0;
    logic [DW-1:0]  bus_wdata = 0, bus_rdata;
    logic           bus_ready;
    logic [NR*DW-1:0] s_regs;
    logic [NR-1:0]  s_upd;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    int  upd_cnt [NR];
    time upd_t   [NR];

    always #2 clk = ~clk;
    always #12 sclk = ~sclk;

    pwb_bridge #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .s_regs(s_regs), .s_upd(s_upd));

    // Record slow-domain update pulses
    always @(posedge sclk) begin
        for (int i = 0; i < NR; i++)
            if (s_upd[i]) begin
                upd_cnt[i]++;
                upd_t[i] = $time;
            end
    end

    // Stimulus table: offset, data; index i targets status bit i
    localparam logic [39:0] VEC [NR] = '{
        {8'h24, 32'hA5A5_0001}, {8'h28, 32'h0000_FFFF}, {8'h2C, 32'hDEAD_BEEF},
        {8'h30, 32'h1234_5678}, {8'h38, 32'hFFFF_0000}, {8'h48, 32'h8000_0001},
        {8'h4C, 32'h0F0F_0F0F}, {8'h50, 32'h7FFF_FFFE}, {8'h54, 32'hC3C3_3C3C},
        {8'h58, 32'h0000_0042}};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int stall);
        stall = 0;
        bus_addr = a; bus_wdata = d; bus_wr = 1; #1;
        while (!bus_ready) begin
            @(negedge clk); #1;
            stall++;
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1; #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] st;
        cyc = 0;
        bus_read(8'h34, st);
        while (st != 0 && cyc < 400) begin
            cyc++;
            bus_read(8'h34, st);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        int st, cyc, c0;
        for (int i = 0; i < NR; i++) begin upd_cnt[i] = 0; upd_t[i] = 0; end
        repeat (20) @(negedge clk);
        rst_n = 1; srst_n = 1;
        @(negedge clk);

        // R1: reset state
        bus_read(8'h34, rd);  check("R1 status", rd, 0);
        bus_read(8'h40, rd);  check("R1 mode", rd, 32'h4);
        bus_read(8'h2C, rd);  check("R1 reg", rd, 0);
        check("R1 s_regs", 32'(|s_regs), 0);
        check("R1 s_upd", 32'(s_upd), 0);

        // Table walk: R10 no stall, R3 bit set, R4 settle, R2 slow copy
        for (int i = 0; i < NR; i++) begin
            c0 = upd_cnt[i];
            bus_write(VEC[i][39:32], VEC[i][31:0], st);
            check("R10 posted stall", st, 0);
            bus_read(8'h34, rd);
            check("R3 pending bit", rd, 32'(1) << i);
            wait_idle(cyc);
            check("R4 clears in bound", 32'(cyc >= 3 && cyc <= 40), 1);
            bus_read(VEC[i][39:32], rd);
            check("R4 readback", rd, VEC[i][31:0]);
            repeat (30) @(negedge clk);
            check("R2 slow value", s_regs[i*DW +: DW], VEC[i][31:0]);
            check("R2 one update", upd_cnt[i] - c0, 1);
        end

        // R6: read while pending returns previous value
        bus_write(8'h28, 32'h5555_AAAA, st);
        bus_read(8'h28, rd);
        check("R6 stale read", rd, 32'h0000_FFFF);
        wait_idle(cyc);
        bus_read(8'h28, rd);
        check("R6 new after clear", rd, 32'h5555_AAAA);

        // R5: second posted write to a pending register is dropped
        repeat (30) @(negedge clk);
        c0 = upd_cnt[2];
        bus_write(8'h2C, 32'h1111_1111, st);
        bus_write(8'h2C, 32'h2222_2222, st);
        wait_idle(cyc);
        bus_read(8'h2C, rd);
        check("R5 dropped write", rd, 32'h1111_1111);
        repeat (30) @(negedge clk);
        check("R5 slow keeps first", s_regs[2*DW +: DW], 32'h1111_1111);
        check("R5 single update", upd_cnt[2] - c0, 1);

        // R9: two registers in flight, order preserved
        bus_write(8'h48, 32'h0000_0505, st);
        bus_write(8'h4C, 32'h0000_0606, st);
        bus_read(8'h34, rd);
        check("R9 both pending", rd, 32'h60);
        wait_idle(cyc);
        repeat (30) @(negedge clk);
        check("R9 order", 32'(upd_t[5] <= upd_t[6]), 1);
        check("R9 value a", s_regs[5*DW +: DW], 32'h0505);
        check("R9 value b", s_regs[6*DW +: DW], 32'h0606);

        // R8: direct mode write, no stall, no pending bit
        bus_write(8'h40, 32'h0, st);
        check("R8 mode no stall", st, 0);
        bus_read(8'h34, rd);  check("R8 no pending", rd, 0);
        bus_read(8'h40, rd);  check("R8 mode readback", rd, 0);

        // R7: non-posted stalls until the update is acknowledged
        bus_write(8'h38, 32'hCAFE_F00D, st);
        check("R7 stalled", 32'(st >= 10), 1);
        bus_read(8'h34, rd);  check("R7 clear at completion", rd, 0);
        bus_read(8'h38, rd);  check("R7 value", rd, 32'hCAFE_F00D);
        check("R7 slow value", s_regs[4*DW +: DW], 32'hCAFE_F00D);

        // R8: restore posted mode
        bus_write(8'h40, 32'h4, st);
        bus_read(8'h40, rd);  check("R8 posted restored", rd, 32'h4);
        bus_write(8'h24, 32'h0BAD_0BAD, st);
        check("R10 posted again", st, 0);
        wait_idle(cyc);

        summary();
    end
endmodule